// File: doc/BRIEF.md
# Printer Port Register Block

This block is a byte-wide register file that looks, from the host side, like a classic printer port driving a byte sink. Three registers share an eight-byte window: a data register at offset 0, a status register at offset 1 and a control register at offset 2. The host uses an address, write data and separate read and write strobes. The block drives a level interrupt and a byte stream made of an 8-bit value and a one-cycle valid pulse.

No cable timing is modelled. The printer handshake is reproduced through register accesses alone:

- Raising the strobe bit in a control write sends the last written data byte to the sink.
- Reading the status register repeatedly walks the acknowledge and busy bits through a fixed toggle sequence.

A separate loadable input-data register stands in for the reverse channel. When the direction bit is set, data reads return this register.

All register updates take effect on the clock edge of the access. Read data is combinational and comes from the state before that edge. A read and a write in the same cycle perform the write only; the read then has no side effect.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, both the output and input data registers hold 0xFF, status reads 0xD9, control reads 0xCC, `irq` is low and `tx_valid` is low.
- R2: Only address bits [2:0] are decoded. Offsets 0 (data), 1 (status) and 2 (control) are backed by registers. Offsets 3 to 7 read as 0xFF and ignore writes. A write to offset 1 changes nothing.
- R3: A control write stores the written value with bits 7 and 6 forced to 1, and a control read returns the stored value.
- R4: A control write with bit 2 (init) equal to 0 sets status to 0xD8 (busy-not 0x80, ack 0x40, online 0x10, error-not 0x08). It emits no byte and leaves the interrupt unchanged.
- R5: A control write with init (bit 2) = 1, select (bit 3) = 1 and strobe (bit 0) = 1 clears status bit 7. If the previously stored strobe bit was 0, the write also emits the output data byte: `tx_valid` is high for exactly the one cycle after the write edge, with `tx_byte` equal to that byte. With select = 0, the write touches neither status nor the stream.
- R6: A control write with init = 1, select = 1 and strobe = 0 sets the interrupt-pending flag when the previously stored control value has bit 4 (interrupt enable) set.
- R7: A status read returns the value held before the edge. After the read, if status bit 7 is 0 and the stored strobe is 0, the bits step: when bit 6 is 1 it is cleared, otherwise bits 7 and 6 are both set.
- R8: A data read returns the input-data register when control bit 5 (direction) is 1, and the last written data byte otherwise.
- R9: `irq` is a registered level equal to the pending flag. A status read clears the flag on its edge.
- R10: A pulse on `rx_load` loads `rx_data` into the input-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Host address, low 3 bits decoded |
| wdata | input | 8 | Host write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational |
| rx_load | input | 1 | Load strobe for the input-data register |
| rx_data | input | 8 | Value for the input-data register |
| irq | output | 1 | Interrupt level |
| tx_valid | output | 1 | Output byte valid, one-cycle pulse |
| tx_byte | output | 8 | Output byte |

## Verification
The bench goes after the edge-sensitive emit. A second strobe-high write must stay silent; a design that compared against the new strobe instead of the stored one would send the byte twice. It walks the acknowledge sequence through 0x59, 0x19 and 0xD9, so a design that stepped before returning the value, or ignored the stored strobe, returns the wrong byte. The interrupt is set from the previously stored enable bit, so a design using the new enable raises it one write early. Address aliasing (0x0A and 0xF8) and the unmapped offsets catch a decoder that looks at too many bits.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
  localparam int BYTE_W = 8;
  localparam int OFFS_W = 3;

  localparam logic [OFFS_W-1:0] OFF_DATA = 3'd0;
  localparam logic [OFFS_W-1:0] OFF_STAT = 3'd1;
  localparam logic [OFFS_W-1:0] OFF_CTRL = 3'd2;

  // status bit positions
  localparam int ST_NBUSY = 7;
  localparam int ST_ACK   = 6;
  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [BYTE_W-1:0] STAT_RST  = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_IDLE = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST  = 8'hCC;
  localparam logic [BYTE_W-1:0] CTRL_FIX  = 8'hC0;
  localparam logic [BYTE_W-1:0] OPEN_BUS  = 8'hFF;
endpackage

// File: rtl/prn_ctrl_unit.sv
module prn_ctrl_unit
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_data,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] dout_q,
  output logic [BYTE_W-1:0] din_q,
  output logic              ev_sts_init,
  output logic              ev_clr_busy,
  output logic              ev_irq_set,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte
);
  logic [BYTE_W-1:0] ctrl_nx;
  logic              armed;
  logic              ev_emit;

  always_comb begin
    ctrl_nx     = wdata | CTRL_FIX;
    ev_sts_init = ctrl_wr && !ctrl_nx[CT_INIT];
    armed       = ctrl_wr && ctrl_nx[CT_INIT] && ctrl_nx[CT_SEL];
    ev_clr_busy = armed && ctrl_nx[CT_STB];
    ev_emit     = ev_clr_busy && !ctrl_q[CT_STB];
    ev_irq_set  = armed && !ctrl_nx[CT_STB] && ctrl_q[CT_IEN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      dout_q   <= OPEN_BUS;
      din_q    <= OPEN_BUS;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= ev_emit;
      if (ev_emit)  tx_byte <= dout_q;
      if (data_wr)  dout_q  <= wdata;
      if (rx_load)  din_q   <= rx_data;
      if (ctrl_wr)  ctrl_q  <= ctrl_nx;
    end
  end

  // R5: the emitted byte is a single-cycle pulse
  a_r5_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);
endmodule

// File: rtl/prn_status_unit.sv
module prn_status_unit
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sts_rd,
  input  logic              ctrl_stb,
  input  logic              ev_sts_init,
  input  logic              ev_clr_busy,
  input  logic              ev_irq_set,
  output logic [BYTE_W-1:0] stat_q,
  output logic              irq_q
);
  logic step_en;

  assign step_en = sts_rd && !stat_q[ST_NBUSY] && !ctrl_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= STAT_RST;
      irq_q  <= 1'b0;
    end else begin
      if (ev_sts_init) begin
        stat_q <= STAT_IDLE;
      end else if (ev_clr_busy) begin
        stat_q[ST_NBUSY] <= 1'b0;
      end else if (step_en) begin
        if (stat_q[ST_ACK]) begin
          stat_q[ST_ACK] <= 1'b0;
        end else begin
          stat_q[ST_NBUSY] <= 1'b1;
          stat_q[ST_ACK]   <= 1'b1;
        end
      end
      if (ev_irq_set)  irq_q <= 1'b1;
      else if (sts_rd) irq_q <= 1'b0;
    end
  end

  // R9: a status read drops the interrupt level
  a_r9_irq_clear: assert property (@(posedge clk) disable iff (rst)
    sts_rd |=> !irq_q);
endmodule

// File: rtl/prn_read_mux.sv
module prn_read_mux
  import prn_port_pkg::*;
(
  input  logic [OFFS_W-1:0] offs,
  input  logic [BYTE_W-1:0] ctrl_q,
  input  logic [BYTE_W-1:0] stat_q,
  input  logic [BYTE_W-1:0] dout_q,
  input  logic [BYTE_W-1:0] din_q,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    unique case (offs)
      OFF_DATA: rdata = ctrl_q[CT_DIR] ? din_q : dout_q;
      OFF_STAT: rdata = stat_q;
      OFF_CTRL: rdata = ctrl_q;
      default:  rdata = OPEN_BUS;
    endcase
  end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  input  logic              rx_load,
  input  logic [7:0]        rx_data,
  output logic              irq,
  output logic              tx_valid,
  output logic [7:0]        tx_byte
);
  logic [OFFS_W-1:0] offs;
  logic              ctrl_wr, data_wr, sts_rd;
  logic [BYTE_W-1:0] ctrl_q, stat_q, dout_q, din_q;
  logic              ev_sts_init, ev_clr_busy, ev_irq_set;

  assign offs    = addr[OFFS_W-1:0];
  assign ctrl_wr = wr_en && (offs == OFF_CTRL);
  assign data_wr = wr_en && (offs == OFF_DATA);
  assign sts_rd  = rd_en && !wr_en && (offs == OFF_STAT);

  prn_ctrl_unit u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ctrl_wr     (ctrl_wr),
    .data_wr     (data_wr),
    .wdata       (wdata),
    .rx_load     (rx_load),
    .rx_data     (rx_data),
    .ctrl_q      (ctrl_q),
    .dout_q      (dout_q),
    .din_q       (din_q),
    .ev_sts_init (ev_sts_init),
    .ev_clr_busy (ev_clr_busy),
    .ev_irq_set  (ev_irq_set),
    .tx_valid    (tx_valid),
    .tx_byte     (tx_byte)
  );

  prn_status_unit u_stat (
    .clk         (clk),
    .rst         (rst),
    .sts_rd      (sts_rd),
    .ctrl_stb    (ctrl_q[CT_STB]),
    .ev_sts_init (ev_sts_init),
    .ev_clr_busy (ev_clr_busy),
    .ev_irq_set  (ev_irq_set),
    .stat_q      (stat_q),
    .irq_q       (irq)
  );

  prn_read_mux u_rmux (
    .offs   (offs),
    .ctrl_q (ctrl_q),
    .stat_q (stat_q),
    .dout_q (dout_q),
    .din_q  (din_q),
    .rdata  (rdata)
  );

  // R4: init-low control write parks the status at the idle pattern
  a_r4_init_low: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offs == OFF_CTRL && !wdata[CT_INIT]) |=> (stat_q == STAT_IDLE));

  // R5: a rising strobe with init and select high sends the held byte
  a_r5_emit: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offs == OFF_CTRL && wdata[CT_INIT] && wdata[CT_SEL] &&
     wdata[CT_STB] && !ctrl_q[CT_STB])
    |=> (tx_valid && tx_byte == $past(dout_q)));

  // R6: strobe-low write with enable previously set raises the interrupt
  a_r6_irq_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offs == OFF_CTRL && wdata[CT_INIT] && wdata[CT_SEL] &&
     !wdata[CT_STB] && ctrl_q[CT_IEN]) |=> irq);
endmodule

// File: tb/prn_port_regs_tb_top.sv
module prn_port_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] addr, wdata, rx_data;
  logic       wr_en, rd_en, rx_load;
  logic [7:0] rdata, tx_byte;
  logic       irq, tx_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  prn_port_regs #(.ADDR_W(8)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .rx_load(rx_load), .rx_data(rx_data),
    .irq(irq), .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  // vector: [39:36] req, [35:34] op (0 write,1 read,2 load), [33:26] addr,
  // [25:18] data, [17:10] expected read, [9] irq, [8] tx, [7:0] tx byte
  function automatic logic [39:0] vec(input logic [3:0] rq, input logic [1:0] op,
      input logic [7:0] a, input logic [7:0] d, input logic [7:0] er,
      input logic ei, input logic et, input logic [7:0] eb);
    return {rq, op, a, d, er, ei, et, eb};
  endfunction

  localparam int NV = 42;
  localparam logic [39:0] VECS [NV] = '{
    vec(1, 1, 8'h02, 8'h00, 8'hCC, 0, 0, 8'h00),  // R1 control reset
    vec(1, 1, 8'h01, 8'h00, 8'hD9, 0, 0, 8'h00),  // R1 status reset
    vec(1, 1, 8'h00, 8'h00, 8'hFF, 0, 0, 8'h00),  // R1 data reset
    vec(2, 1, 8'h05, 8'h00, 8'hFF, 0, 0, 8'h00),  // R2 unmapped
    vec(8, 0, 8'h00, 8'h41, 8'h00, 0, 0, 8'h00),  // R8 data write
    vec(8, 1, 8'h00, 8'h00, 8'h41, 0, 0, 8'h00),
    vec(2, 0, 8'h05, 8'h00, 8'h00, 0, 0, 8'h00),  // R2 ignored write
    vec(2, 0, 8'h01, 8'h00, 8'h00, 0, 0, 8'h00),  // R2 status write
    vec(2, 1, 8'h01, 8'h00, 8'hD9, 0, 0, 8'h00),
    vec(2, 1, 8'h00, 8'h00, 8'h41, 0, 0, 8'h00),
    vec(5, 0, 8'h02, 8'h0D, 8'h00, 0, 1, 8'h41),  // R5 emit
    vec(3, 1, 8'h02, 8'h00, 8'hCD, 0, 0, 8'h00),  // R3 forced bits
    vec(7, 1, 8'h01, 8'h00, 8'h59, 0, 0, 8'h00),  // R7 no step, strobe 1
    vec(5, 0, 8'h02, 8'h0D, 8'h00, 0, 0, 8'h00),  // R5 no second emit
    vec(6, 0, 8'h02, 8'h0C, 8'h00, 0, 0, 8'h00),  // R6 enable was off
    vec(7, 1, 8'h01, 8'h00, 8'h59, 0, 0, 8'h00),  // R7 ack clears
    vec(7, 1, 8'h01, 8'h00, 8'h19, 0, 0, 8'h00),  // R7 both set
    vec(7, 1, 8'h01, 8'h00, 8'hD9, 0, 0, 8'h00),
    vec(5, 0, 8'h02, 8'h05, 8'h00, 0, 0, 8'h00),  // R5 select low
    vec(5, 1, 8'h01, 8'h00, 8'hD9, 0, 0, 8'h00),
    vec(4, 0, 8'h02, 8'h08, 8'h00, 0, 0, 8'h00),  // R4 init low
    vec(4, 1, 8'h01, 8'h00, 8'hD8, 0, 0, 8'h00),
    vec(3, 1, 8'h02, 8'h00, 8'hC8, 0, 0, 8'h00),
    vec(2, 0, 8'h0A, 8'h2C, 8'h00, 0, 0, 8'h00),  // R2 alias to control
    vec(8, 1, 8'h00, 8'h00, 8'hFF, 0, 0, 8'h00),  // R8 input register
    vec(10, 2, 8'h00, 8'h5A, 8'h00, 0, 0, 8'h00), // R10 load
    vec(10, 1, 8'h00, 8'h00, 8'h5A, 0, 0, 8'h00),
    vec(2, 1, 8'hF8, 8'h00, 8'h5A, 0, 0, 8'h00),  // R2 alias to data
    vec(6, 0, 8'h02, 8'h1C, 8'h00, 0, 0, 8'h00),  // R6 old enable off
    vec(6, 0, 8'h02, 8'h1C, 8'h00, 1, 0, 8'h00),  // R6 old enable on
    vec(8, 1, 8'h00, 8'h00, 8'h41, 1, 0, 8'h00),  // R8 direction 0
    vec(9, 1, 8'h01, 8'h00, 8'hD8, 0, 0, 8'h00),  // R9 read clears
    vec(6, 0, 8'h02, 8'h0C, 8'h00, 1, 0, 8'h00),  // R6
    vec(5, 0, 8'h02, 8'h0D, 8'h00, 1, 1, 8'h41),  // R5 emit, irq held
    vec(9, 1, 8'h01, 8'h00, 8'h58, 0, 0, 8'h00),  // R9
    vec(6, 0, 8'h02, 8'h0C, 8'h00, 0, 0, 8'h00),
    vec(7, 1, 8'h01, 8'h00, 8'h58, 0, 0, 8'h00),  // R7
    vec(7, 1, 8'h01, 8'h00, 8'h18, 0, 0, 8'h00),  // R7
    vec(2, 1, 8'h03, 8'h00, 8'hFF, 0, 0, 8'h00),  // R2
    vec(2, 1, 8'h07, 8'h00, 8'hFF, 0, 0, 8'h00),  // R2
    vec(4, 0, 8'h02, 8'h00, 8'h00, 0, 0, 8'h00),  // R4
    vec(3, 1, 8'h02, 8'h00, 8'hC0, 0, 0, 8'h00)   // R3
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic do_op(input logic [1:0] op, input logic [7:0] a,
                       input logic [7:0] d, output logic [7:0] rd_seen);
    addr = a; wdata = d; rx_data = d;
    wr_en = (op == 2'd0); rd_en = (op == 2'd1); rx_load = (op == 2'd2);
    #1 rd_seen = rdata;
    @(posedge clk);
    #1 wr_en = 1'b0; rd_en = 1'b0; rx_load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] rv;
    addr = 0; wdata = 0; wr_en = 0; rd_en = 0; rx_load = 0; rx_data = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check8("R1 irq after reset", {7'd0, irq}, 8'h00);
    check8("R1 tx_valid after reset", {7'd0, tx_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      string tg;
      v = VECS[i];
      tg = $sformatf("R%0d vec%0d", v[39:36], i);
      do_op(v[35:34], v[33:26], v[25:18], rv);
      if (v[35:34] == 2'd1) check8({tg, " rdata"}, rv, v[17:10]);
      check8({tg, " irq"}, {7'd0, irq}, {7'd0, v[9]});
      check8({tg, " tx_valid"}, {7'd0, tx_valid}, {7'd0, v[8]});
      if (v[8]) check8({tg, " tx_byte"}, tx_byte, v[7:0]);
    end

    // R1: reset while an interrupt is pending restores every register
    do_op(2'd0, 8'h02, 8'h1C, rv);
    do_op(2'd0, 8'h02, 8'h1C, rv);
    check8("R6 pending before reset", {7'd0, irq}, 8'h01);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check8("R1 irq cleared by reset", {7'd0, irq}, 8'h00);
    do_op(2'd1, 8'h02, 8'h00, rv); check8("R1 control", rv, 8'hCC);
    do_op(2'd1, 8'h01, 8'h00, rv); check8("R1 status", rv, 8'hD9);
    do_op(2'd1, 8'h00, 8'h00, rv); check8("R1 output data", rv, 8'hFF);
    do_op(2'd0, 8'h02, 8'h2C, rv);
    do_op(2'd1, 8'h00, 8'h00, rv); check8("R1 input data", rv, 8'hFF);

    // R5: emit after a fresh data byte, from strobe low
    do_op(2'd0, 8'h00, 8'hA7, rv);
    do_op(2'd0, 8'h02, 8'h0C, rv);
    do_op(2'd0, 8'h02, 8'h0D, rv);
    check8("R5 tx_valid", {7'd0, tx_valid}, 8'h01);
    check8("R5 tx_byte", tx_byte, 8'hA7);
    @(negedge clk);
    check8("R5 pulse ends", {7'd0, tx_valid}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule